// File: doc/BRIEF.md
# Latched-Address Inverting Scratchpad RAM

A small read/write store of 16 words, 4 bits each, controlled by two active-low strobes: a memory enable and a write enable. A falling edge on the memory enable selects the block and captures the address into an internal register. The caller may then change the address lines, because all later accesses use the captured word address. While the enable stays low, the write strobe chooses between storing the data input and reading the stored word back. The read path returns the bitwise inverse of what was stored.

The block runs on one system clock. Both strobes pass through `SYNC_STAGES` synchronizer flops and then an edge detector. The address is sampled on the clock edge at which the synchronized enable is first seen low after being high. That is the `SYNC_STAGES+1`-th rising edge after the enable falls, so the caller holds the address that long. The high-impedance state of the data pins is modelled by a registered output-enable flag next to the data bus, and a pad wrapper can build real tri-state pins from it. Memory contents are not cleared by reset.

Top module: `scratch_ram`

## Requirements
- R1: While selected with the write strobe low, the data input is stored into the word at the captured address on every clock edge at which both synchronized strobes are low.
- R2: The address is captured only on the clock edge where a high-to-low transition of the synchronized enable is detected. Address changes after that edge have no effect on which word is accessed.
- R3: While selected with the write strobe high, `dout_oe` is 1 and `dout` equals the bitwise inverse of the stored word. Both are valid no later than `SYNC_STAGES+2` rising edges after the read condition is applied.
- R4: Reading never changes any stored word, however often it is repeated.
- R5: `dout_oe` is 0 while a write is taking place.
- R6: While the enable is high, nothing is written whatever the write strobe and data inputs do, and `dout_oe` is 0.
- R7: After reset, an enable held low without first going high does not select the block: `dout_oe` stays 0 and no write occurs.
- R8: Synchronous reset sets `dout_oe` to 0 and `dout` to 0 and deselects the block. Stored words are kept.
- R9: Changes on the data input while no write is taking place leave the stored words and the read value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_en_n | input | 1 | Memory enable, active low; its falling edge selects and captures the address |
| wr_en_n | input | 1 | Write strobe, active low; high means read |
| addr | input | ADDR_W | Word address, sampled on the detected enable fall |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Inverted read data, meaningful when `dout_oe` is 1 |
| dout_oe | output | 1 | Output drive enable; 0 stands for high impedance |

## Verification
A wrong captured address shows up on the first read after selection as the inverse of a different word. A missed or spurious write shows up when that location is next read, which may be many transactions later. For that reason every location is seeded first and the whole array is swept again at the end. A selection flag that sets without a true enable edge, or a write path that is not gated by it, shows as `dout_oe` rising, or as a stored word changing, within a few cycles of a power-up hold with the enable low. A read path that is not inverted is caught on the first compare.

// File: rtl/scratch_ram.sv
module scratch_ram #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SYNC_STAGES-1:0]        me_sync, we_sync;
  logic                          me_d1, sel;
  logic [ADDR_W-1:0]             addr_q;
  logic [DEPTH-1:0][DATA_W-1:0]  mem;

  wire me_q      = me_sync[SYNC_STAGES-1];
  wire we_q      = we_sync[SYNC_STAGES-1];
  wire fall      = me_d1 & ~me_q;
  wire active    = sel & ~me_q;
  wire write_now = active & ~we_q;
  wire read_now  = active & we_q;

  // Enable chain resets low so a held-low enable never looks like an edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      me_sync <= '0;
      we_sync <= '1;
      me_d1   <= 1'b0;
    end else begin
      me_sync[0] <= mem_en_n;
      we_sync[0] <= wr_en_n;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        me_sync[i] <= me_sync[i-1];
        we_sync[i] <= we_sync[i-1];
      end
      me_d1 <= me_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= 1'b0;
      addr_q <= '0;
    end else if (fall) begin
      sel    <= 1'b1;
      addr_q <= addr;
    end else if (me_q) begin
      sel    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (write_now) mem[addr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= read_now;
      dout    <= read_now ? ~mem[addr_q] : '0;
    end
  end

  assert_sel_needs_edge_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sel) |-> $past(fall));

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (rst)
    (sel && !me_q) |=> $stable(addr_q));

  assert_read_keeps_mem_R4: assert property (@(posedge clk) disable iff (rst)
    read_now |=> $stable(mem));

  assert_write_floats_R5: assert property (@(posedge clk) disable iff (rst)
    !we_q |=> !dout_oe);

  assert_disabled_floats_R6: assert property (@(posedge clk) disable iff (rst)
    me_q |=> !dout_oe);

  assert_disabled_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    me_q |=> $stable(mem));

  assert_oe_means_read_R3: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> $past(sel && !me_q && we_q));
endmodule

// File: tb/test_scratch_ram.sv
module test_scratch_ram;
  localparam int AW = 4, DW = 4, S = 2, DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, mem_en_n = 1'b1, wr_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  logic [DW-1:0] model [DEPTH];
  int checks = 0, fails = 0;
  bit done = 0;
  int unsigned seed_dummy;

  always #4 clk = ~clk;

  scratch_ram #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(S)) i_scratch_ram (
    .clk(clk), .rst(rst), .mem_en_n(mem_en_n), .wr_en_n(wr_en_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe));

  function automatic logic [DW-1:0] exp_read(logic [DW-1:0] w);
    return ~w;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // R2: hold address through capture edge, then scramble it
  task automatic select(logic [AW-1:0] a);
    mem_en_n = 1'b1; wr_en_n = 1'b1;
    tick(S + 2);
    check("R6 oe low while disabled", 8'(dout_oe), 8'd0);
    mem_en_n = 1'b0; addr = a;
    tick(S + 1);
    addr = AW'($urandom);
    tick(2);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    din = d; wr_en_n = 1'b0;
    tick(S + 2);
    check("R5 oe low during write", 8'(dout_oe), 8'd0);
    wr_en_n = 1'b1;
    tick(S + 1);
    din = DW'($urandom);
    model[a] = d;
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    wr_en_n = 1'b1;
    din = DW'($urandom);
    tick(S + 3);
    check({req, " oe"}, 8'(dout_oe), 8'd1);
    check({req, " data"}, 8'(dout), 8'(exp_read(model[a])));
  endtask

  initial begin
    seed_dummy = $urandom(32'h5EED_0042);
    tick(3);
    check("R8 reset oe", 8'(dout_oe), 8'd0);
    check("R8 reset dout", 8'(dout), 8'd0);
    rst = 1'b0;
    tick(2);

    for (int a = 0; a < DEPTH; a++) begin
      select(AW'(a));
      do_write(AW'(a), DW'($urandom));
      do_read(AW'(a), "R1 R3 fill readback");
    end
    select(4'd15); do_write(4'd15, 4'hF); do_read(4'd15, "R3 all-ones reads zero");
    select(4'd0);  do_write(4'd0, 4'h0);  do_read(4'd0, "R3 all-zeros reads ones");

    for (int it = 0; it < 150; it++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      select(a);
      if ($urandom_range(0, 1) == 1) begin
        do_write(a, DW'($urandom));
        do_read(a, "R2 random write then read");
      end else begin
        do_read(a, "R4 R9 random read");
        do_read(a, "R4 repeated read");
      end
    end

    // R6: writes while disabled are ignored
    mem_en_n = 1'b1;
    tick(S + 2);
    wr_en_n = 1'b0;
    for (int k = 0; k < 8; k++) begin
      din = DW'($urandom); addr = AW'($urandom);
      tick(1);
      check("R6 oe low disabled write", 8'(dout_oe), 8'd0);
    end
    wr_en_n = 1'b1;
    tick(S + 2);

    // R7: enable held low across reset never selects
    mem_en_n = 1'b0; rst = 1'b1;
    tick(3);
    rst = 1'b0;
    din = ~model[0]; wr_en_n = 1'b0;
    for (int k = 0; k < 10; k++) begin
      tick(1);
      check("R7 no selection while held low (write)", 8'(dout_oe), 8'd0);
    end
    wr_en_n = 1'b1;
    tick(S + 3);
    check("R7 no selection while held low (read)", 8'(dout_oe), 8'd0);
    select(4'd0);
    do_read(4'd0, "R7 held-low write ignored");

    for (int a = 0; a < DEPTH; a++) begin
      select(AW'(a));
      do_read(AW'(a), "R4 R6 final sweep");
    end
    mem_en_n = 1'b1;
    tick(S + 2);
    check("R6 oe low after final deselect", 8'(dout_oe), 8'd0);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end
endmodule